// File: doc/BRIEF.md
# Flag-Only Logical Test Unit

This block is an execution slice for compare-style logical instructions that
keep only the condition flags. A 32-bit register operand is combined with a
second operand (already produced by an upstream shifter) by either a bitwise
AND or a bitwise XOR. The combined value is used only to derive the negative
and zero flags and is then dropped. It never reaches the register file.

The carry flag is not computed from the logic operation. It is loaded from
the shifter's carry-out, and only when the shifter marks that carry as valid.
The overflow flag is kept in the block but no operation can write it. A
condition-pass input gates each issue slot. If the condition fails, nothing
changes.

An issue is refused when the index of the register operand names the stack
pointer or the program counter. A refused issue raises an error strobe and
leaves the flags as they were. All outputs are registered. They show the
effect of an issue in the cycle that follows the clock edge at which the
issue was sampled.

Top module: `flag_test_unit`

## Requirements
- R1: With `opSel` = 0 (AND test) on a passed, legal issue, the next cycle shows `flagN` equal to bit 31 of `opA & opB`, and shows `flagZ` high exactly when `opA & opB` is zero.
- R2: With `opSel` = 1 (XOR test) on a passed, legal issue, the next cycle shows `flagN` equal to `opA[31] ^ opB[31]`, and shows `flagZ` high exactly when `opA == opB`.
- R3: On a passed, legal issue with `shCarryValid` high, `flagC` takes the value of `shCarry` in the next cycle. With `shCarryValid` low, `flagC` keeps its value.
- R4: No operation changes `flagV`. It holds the value it received at reset, which is 0.
- R5: When `condPass` is low, the next cycle shows all four flags unchanged and shows `flagWr` and `illegalErr` low.
- R6: A passed issue whose `rnIdx` is 13 (stack pointer) or 15 (program counter) raises `illegalErr` for one cycle and holds `flagWr` low. All flags stay unchanged.
- R7: A synchronous `rst` clears `flagN`, `flagZ`, `flagC`, `flagV`, `flagWr` and `illegalErr` at the next clock edge.
- R8: `flagWr` is high for exactly the one cycle that follows each passed, legal issue, and `illegalErr` is then low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| condPass | input | 1 | The issue in this cycle passed its condition |
| opSel | input | 1 | Operation select: 0 = AND test, 1 = XOR test |
| rnIdx | input | 4 | Register index of the first operand |
| opA | input | 32 | First (register) operand |
| opB | input | 32 | Second operand from the shifter |
| shCarry | input | 1 | Carry-out of the second-operand shifter |
| shCarryValid | input | 1 | The shifter produced a carry-out this issue |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagC | output | 1 | Carry flag |
| flagV | output | 1 | Overflow flag |
| flagWr | output | 1 | Flag-write strobe for the issue sampled at the previous edge |
| illegalErr | output | 1 | Illegal-operand error for the issue sampled at the previous edge |

## Verification
On every cycle the assertions check these properties: the overflow flag stays
fixed, all flags hold after a failed condition, the carry holds when no
shifter carry is offered, a stack-pointer or program-counter operand is
refused, each legal passed issue produces a write strobe, and the XOR-test
negative flag follows the two sign bits. The bench scenarios are needed to
show the full value of the zero flag for both operations across edge
patterns: all-ones masks, single-bit tests, equal and unequal operands, and
differences only in the top or bottom bit. They also show carry loading with
both polarities, and that a reset in the middle of a run clears every output.

// File: rtl/ftu_pkg.sv
package ftu_pkg;

  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;

  typedef enum logic {
    OP_AND_TEST = 1'b0,
    OP_XOR_TEST = 1'b1
  } ftuOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadNZ;   // load negative and zero flags
    logic loadC;    // load carry from the shifter
    logic accept;   // legal, passed issue
    logic refuse;   // passed issue naming a forbidden register
  } ftuCtl_t;

endpackage

// File: rtl/ftu_ctrl.sv
module ftu_ctrl
  import ftu_pkg::*;
#(
  parameter int IDX_BITS = IDX_W,
  parameter int SP_INDEX = 13,
  parameter int PC_INDEX = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                condPass,
  input  logic [IDX_BITS-1:0] rnIdx,
  input  logic                shCarryValid,
  output ftuCtl_t             ctl,
  output logic                flagWr,
  output logic                illegalErr
);

  localparam logic [IDX_BITS-1:0] SP_CODE = IDX_BITS'(SP_INDEX);
  localparam logic [IDX_BITS-1:0] PC_CODE = IDX_BITS'(PC_INDEX);

  logic forbiddenIdx;
  logic acceptNow;
  logic refuseNow;

  always_comb begin
    forbiddenIdx = (rnIdx == SP_CODE) || (rnIdx == PC_CODE);
    acceptNow    = condPass && !forbiddenIdx;
    refuseNow    = condPass && forbiddenIdx;
  end

  always_comb begin
    ctl.accept = acceptNow;
    ctl.refuse = refuseNow;
    ctl.loadNZ = acceptNow;
    ctl.loadC  = acceptNow && shCarryValid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flagWr     <= 1'b0;
      illegalErr <= 1'b0;
    end else begin
      flagWr     <= acceptNow;
      illegalErr <= refuseNow;
    end
  end

endmodule

// File: rtl/ftu_datapath.sv
module ftu_datapath
  import ftu_pkg::*;
#(
  parameter int WIDTH   = DATA_W,
  parameter int GROUP_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  ftuCtl_t          ctl,
  input  logic             opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             shCarry,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagC,
  output logic             flagV
);

  localparam int NGROUPS = (WIDTH + GROUP_W - 1) / GROUP_W;
  localparam int PADDED  = NGROUPS * GROUP_W;

  logic [WIDTH-1:0]   logicRes;
  logic [PADDED-1:0]  padRes;
  logic [NGROUPS-1:0] groupNonZero;
  logic               resZero;
  logic               resNeg;

  // Discarded logical result: feeds the flags only
  always_comb begin
    unique case (ftuOp_e'(opSel))
      OP_AND_TEST: logicRes = opA & opB;
      OP_XOR_TEST: logicRes = opA ^ opB;
      default:     logicRes = opA & opB;
    endcase
    padRes = PADDED'(logicRes);
  end

  // Two-level zero detect: per-group OR, then NOR across groups
  genvar g;
  generate
    for (g = 0; g < NGROUPS; g++) begin : gZeroGrp
      assign groupNonZero[g] = |padRes[g*GROUP_W +: GROUP_W];
    end
  endgenerate

  always_comb begin
    resZero = ~|groupNonZero;
    resNeg  = logicRes[WIDTH-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flagN <= 1'b0;
      flagZ <= 1'b0;
      flagC <= 1'b0;
      flagV <= 1'b0;
    end else begin
      if (ctl.loadNZ) begin
        flagN <= resNeg;
        flagZ <= resZero;
      end
      if (ctl.loadC) begin
        flagC <= shCarry;
      end
      // flagV has no write path
    end
  end

endmodule

// File: rtl/flag_test_unit.sv
module flag_test_unit
  import ftu_pkg::*;
#(
  parameter int WIDTH    = DATA_W,
  parameter int IDX_BITS = IDX_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                condPass,
  input  logic                opSel,
  input  logic [IDX_BITS-1:0] rnIdx,
  input  logic [WIDTH-1:0]    opA,
  input  logic [WIDTH-1:0]    opB,
  input  logic                shCarry,
  input  logic                shCarryValid,
  output logic                flagN,
  output logic                flagZ,
  output logic                flagC,
  output logic                flagV,
  output logic                flagWr,
  output logic                illegalErr
);

  ftuCtl_t ctl;

  ftu_ctrl #(.IDX_BITS(IDX_BITS)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .condPass     (condPass),
    .rnIdx        (rnIdx),
    .shCarryValid (shCarryValid),
    .ctl          (ctl),
    .flagWr       (flagWr),
    .illegalErr   (illegalErr)
  );

  ftu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .opSel   (opSel),
    .opA     (opA),
    .opB     (opB),
    .shCarry (shCarry),
    .flagN   (flagN),
    .flagZ   (flagZ),
    .flagC   (flagC),
    .flagV   (flagV)
  );

endmodule

// File: rtl/flag_test_unit_chk.sv
module flag_test_unit_chk #(
  parameter int WIDTH    = 32,
  parameter int IDX_BITS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                condPass,
  input logic                opSel,
  input logic [IDX_BITS-1:0] rnIdx,
  input logic [WIDTH-1:0]    opA,
  input logic [WIDTH-1:0]    opB,
  input logic                shCarryValid,
  input logic                flagN,
  input logic                flagZ,
  input logic                flagC,
  input logic                flagV,
  input logic                flagWr,
  input logic                illegalErr
);

  logic badIdx;
  assign badIdx = (rnIdx == IDX_BITS'(13)) || (rnIdx == IDX_BITS'(15));

  AST_V_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(flagV) |=> $stable(flagV)); // R4

  AST_HOLD_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
    !condPass |=> ($stable({flagN, flagZ, flagC}) && !flagWr && !illegalErr)); // R5

  AST_REFUSE_BAD_IDX: assert property (@(posedge clk) disable iff (rst)
    (condPass && badIdx) |=> (illegalErr && !flagWr && $stable({flagN, flagZ, flagC}))); // R6

  AST_C_KEEP: assert property (@(posedge clk) disable iff (rst)
    (condPass && !shCarryValid) |=> $stable(flagC)); // R3

  AST_XOR_SIGN: assert property (@(posedge clk) disable iff (rst)
    (condPass && !badIdx && opSel) |=> (flagN == ($past(opA[WIDTH-1]) ^ $past(opB[WIDTH-1])))); // R2

  AST_WR_STROBE: assert property (@(posedge clk) disable iff (rst)
    (condPass && !badIdx) |=> (flagWr && !illegalErr)); // R8

endmodule

bind flag_test_unit flag_test_unit_chk #(.WIDTH(WIDTH), .IDX_BITS(IDX_BITS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .condPass     (condPass),
  .opSel        (opSel),
  .rnIdx        (rnIdx),
  .opA          (opA),
  .opB          (opB),
  .shCarryValid (shCarryValid),
  .flagN        (flagN),
  .flagZ        (flagZ),
  .flagC        (flagC),
  .flagV        (flagV),
  .flagWr       (flagWr),
  .illegalErr   (illegalErr)
);

// File: tb/test_flag_test_unit.sv
module test_flag_test_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        condPass = 1'b0;
  logic        opSel = 1'b0;
  logic [3:0]  rnIdx = 4'd0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        shCarry = 1'b0;
  logic        shCarryValid = 1'b0;
  logic        flagN, flagZ, flagC, flagV, flagWr, illegalErr;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [5:0] outs;  // {N,Z,C,V,wr,err}
    string      tag;
  } expItem_t;

  expItem_t scoreQ[$];

  // Reference flag state
  logic mN = 1'b0, mZ = 1'b0, mC = 1'b0, mV = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_test_unit i_flag_test_unit (
    .clk          (clk),
    .rst          (rst),
    .condPass     (condPass),
    .opSel        (opSel),
    .rnIdx        (rnIdx),
    .opA          (opA),
    .opB          (opB),
    .shCarry      (shCarry),
    .shCarryValid (shCarryValid),
    .flagN        (flagN),
    .flagZ        (flagZ),
    .flagC        (flagC),
    .flagV        (flagV),
    .flagWr       (flagWr),
    .illegalErr   (illegalErr)
  );

  // Driver: set inputs away from the edge, push expectation, wait one edge
  task automatic issue(input logic r, input logic cp, input logic sel,
                       input logic [3:0] idx, input logic [31:0] a,
                       input logic [31:0] b, input logic cy, input logic cyv,
                       input string tag);
    logic [31:0] res;
    logic wr, err;
    expItem_t it;
    @(negedge clk);
    rst = r; condPass = cp; opSel = sel; rnIdx = idx;
    opA = a; opB = b; shCarry = cy; shCarryValid = cyv;
    wr = 1'b0; err = 1'b0;
    if (r) begin
      mN = 1'b0; mZ = 1'b0; mC = 1'b0; mV = 1'b0;
    end else if (cp && (idx == 4'd13 || idx == 4'd15)) begin
      err = 1'b1;
    end else if (cp) begin
      res = sel ? (a ^ b) : (a & b);
      mN = res[31];
      mZ = (res == 32'd0);
      if (cyv) mC = cy;
      wr = 1'b1;
    end
    it.outs = {mN, mZ, mC, mV, wr, err};
    it.tag  = tag;
    scoreQ.push_back(it);
    @(posedge clk);
  endtask

  // Monitor: compare one cycle after the sampling edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (scoreQ.size() > 0) begin
        expItem_t e;
        logic [5:0] act;
        e = scoreQ.pop_front();
        act = {flagN, flagZ, flagC, flagV, flagWr, illegalErr};
        testsRun++;
        if (act !== e.outs) begin
          testsFailed++;
          $display("FAIL %s: got NZCV_wr_err=%b expected %b", e.tag, act, e.outs);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    // R7: reset state
    issue(1, 0, 0, 4'd0, '0, '0, 0, 0, "R7 reset");
    issue(1, 0, 0, 4'd0, '0, '0, 0, 0, "R7 reset hold");
    // R1: AND test patterns
    issue(0, 1, 0, 4'd0, 32'h0000_03F8, 32'h0000_0008, 0, 0, "R1 single bit set");
    issue(0, 1, 0, 4'd1, 32'h0000_03F8, 32'h0000_0004, 0, 0, "R1 single bit clear");
    issue(0, 1, 0, 4'd2, 32'hFFFF_FFFF, 32'h8000_0000, 0, 0, "R1 sign bit");
    issue(0, 1, 0, 4'd3, 32'hAAAA_AAAA, 32'h5555_5555, 0, 0, "R1 disjoint");
    issue(0, 1, 0, 4'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, "R1 all ones");
    // R2: XOR test
    issue(0, 1, 1, 4'd5, 32'h1234_5678, 32'h1234_5678, 0, 0, "R2 equal");
    issue(0, 1, 1, 4'd6, 32'h1234_5678, 32'h1234_5679, 0, 0, "R2 differ lsb");
    issue(0, 1, 1, 4'd7, 32'h8000_0000, 32'h0000_0000, 0, 0, "R2 differ msb");
    issue(0, 1, 1, 4'd8, 32'h8000_0001, 32'h8000_0001, 0, 0, "R2 both negative equal");
    issue(0, 1, 1, 4'd9, 32'hF000_0000, 32'h0F00_0000, 0, 0, "R2 sign mix");
    // R3: carry load and keep
    issue(0, 1, 0, 4'd0, 32'h1, 32'h1, 1, 1, "R3 carry load 1");
    issue(0, 1, 1, 4'd0, 32'h1, 32'h2, 0, 0, "R3 carry kept");
    issue(0, 1, 1, 4'd0, 32'h1, 32'h1, 0, 1, "R3 carry load 0");
    issue(0, 1, 0, 4'd0, 32'h0, 32'h0, 1, 1, "R3 carry load again");
    // R5: condition fail holds
    issue(0, 0, 1, 4'd0, 32'hFFFF_FFFF, 32'h0, 0, 1, "R5 cond fail");
    issue(0, 0, 0, 4'd0, 32'h8000_0000, 32'h8000_0000, 0, 1, "R5 cond fail again");
    // R6: forbidden register
    issue(0, 1, 1, 4'd13, 32'h8000_0000, 32'h0, 0, 1, "R6 stack pointer");
    issue(0, 1, 0, 4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1, "R6 program counter");
    issue(0, 1, 0, 4'd14, 32'hFFFF_FFFF, 32'h8000_0000, 0, 1, "R8 index 14 legal");
    issue(0, 0, 0, 4'd13, 32'h0, 32'h0, 1, 1, "R5 fail with bad index");
    // R8: back-to-back strobes
    issue(0, 1, 1, 4'd2, 32'h0, 32'h1, 1, 1, "R8 strobe 1");
    issue(0, 1, 0, 4'd3, 32'h3, 32'h4, 1, 0, "R8 strobe 2");
    // R4: V untouched across all of the above
    issue(0, 1, 1, 4'd4, 32'h7FFF_FFFF, 32'h8000_0000, 1, 1, "R4 V untouched");
    // R7: reset mid-run clears set flags
    issue(1, 1, 0, 4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, "R7 mid-run reset");
    issue(0, 0, 0, 4'd0, '0, '0, 0, 0, "R7 after reset");
    @(negedge clk);
    condPass = 1'b0;
    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule